// File: doc/BRIEF.md
# Search-Based Seven-Segment Digit Recovery

This block recovers the decimal value shown on one seven-segment digit by search rather than by a lookup decode. An internal decimal counter feeds a digit-to-segment encoder. The encoder output is compared bit for bit with a captured copy of the segment lines. While the two patterns differ, the counter keeps stepping. When every segment agrees, the counter stops and its value is presented as the digit, together with a match flag.

The encoder follows the backplane phase, so that it produces the same polarity as the raw segment lines. Segments are latched only when the capture stage pulses its strobe to signal that the lines are stable. If ten consecutive comparisons fail after a strobe, a no-match flag is raised and the last good digit is kept.

Top module: `seg_search_decoder`

## Requirements
- R1: After reset, `digit_out` is 0 and both `match_out` and `no_match` are 0.
- R2: Segment bit 6 is segment a and bit 0 is segment g, with 1 meaning lit when `bp_phase` is 0. The patterns are 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=5F, 7=70, 8=7F, 9=7B (hex). After a strobe with a lit pattern for digit d, `match_out` goes to 1 with `digit_out`=d within 11 cycles.
- R3: When `bp_phase` is 1 at the strobe, all seven segment bits are taken as inverted, and the inverted pattern of digit d resolves to d.
- R4: The search counter advances by one on each miss, wraps from 9 to 0, and never holds a value above 9.
- R5: While no search is in progress, the counter is inhibited and the outputs hold their values.
- R6: If ten comparisons in a row fail after a strobe, `no_match` goes to 1, `match_out` stays 0, and `digit_out` keeps the last matched digit.
- R7: Changes on `seg_in` and `bp_phase` without `sample_stb` have no effect on the outputs.
- R8: A strobe clears `match_out` and `no_match` on the next cycle and restarts the search, including a strobe that arrives during a search.
- R9: `match_out` and `no_match` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_in | input | 7 | Captured segment levels, a in bit 6 to g in bit 0 |
| bp_phase | input | 1 | Backplane phase at capture; 1 means segments are inverted |
| sample_stb | input | 1 | One-cycle pulse: segment inputs are stable, latch them |
| digit_out | output | 4 | Recovered digit, 0 to 9 |
| match_out | output | 1 | The digit matches the latched segments |
| no_match | output | 1 | The last search ended without a match |

## Verification
A counter that steps wrongly, wraps late or leaves the decimal range shows up at the ports as a wrong digit or a late `match_out` within the eleven cycles that follow a strobe. The reference model tracks every cycle, so an error is seen on the cycle it happens. A bad encoder entry or a phase handling error gives a wrong digit or a false `no_match` on the first search that uses that digit or phase. A latch that follows `seg_in` without the strobe shows as outputs that change while the bench holds the strobe low.

// File: rtl/seg_search_decoder.sv
module seg_search_decoder #(
  parameter int SEGS = 7,
  parameter int DW   = 4,
  parameter int LAST = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SEGS-1:0] seg_in,
  input  logic            bp_phase,
  input  logic            sample_stb,
  output logic [DW-1:0]   digit_out,
  output logic            match_out,
  output logic            no_match
);

  localparam logic [DW-1:0] TOP = DW'(LAST);

  function automatic logic [6:0] glyph(input logic [DW-1:0] v);
    case (v)
      4'd0:    glyph = 7'h7E;
      4'd1:    glyph = 7'h30;
      4'd2:    glyph = 7'h6D;
      4'd3:    glyph = 7'h79;
      4'd4:    glyph = 7'h33;
      4'd5:    glyph = 7'h5B;
      4'd6:    glyph = 7'h5F;
      4'd7:    glyph = 7'h70;
      4'd8:    glyph = 7'h7F;
      4'd9:    glyph = 7'h7B;
      default: glyph = 7'h00;
    endcase
  endfunction

  logic [SEGS-1:0] seg_q;
  logic            ph_q;
  logic            busy;
  logic [DW-1:0]   cnt;
  logic [DW-1:0]   steps;
  logic [SEGS-1:0] enc;
  logic            hit;

  assign enc = glyph(cnt) ^ {SEGS{ph_q}};
  assign hit = busy && (enc == seg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q     <= '0;
      ph_q      <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      steps     <= '0;
      digit_out <= '0;
      match_out <= 1'b0;
      no_match  <= 1'b0;
    end else if (sample_stb) begin
      seg_q     <= seg_in;
      ph_q      <= bp_phase;
      busy      <= 1'b1;
      steps     <= '0;
      match_out <= 1'b0;
      no_match  <= 1'b0;
    end else if (busy) begin
      if (hit) begin
        busy      <= 1'b0;
        digit_out <= cnt;
        match_out <= 1'b1;
      end else begin
        cnt   <= (cnt == TOP) ? '0 : cnt + 1'b1;
        steps <= steps + 1'b1;
        if (steps == TOP) begin
          busy     <= 1'b0;
          no_match <= 1'b1;
        end
      end
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);

  // R4
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !hit && !sample_stb && cnt == TOP |=> cnt == '0);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(cnt));

  // R6
  miss_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> steps <= TOP);

  // R2
  match_true_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_out |-> ((glyph(digit_out) ^ {SEGS{ph_q}}) == seg_q));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_out && no_match));

endmodule

// File: tb/seg_search_decoder_test.sv
module seg_search_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] seg_in = 7'h00;
  logic       bp_phase = 1'b0;
  logic       sample_stb = 1'b0;
  logic [3:0] digit_out;
  logic       match_out;
  logic       no_match;

  always #2 clk = ~clk;

  seg_search_decoder uut (
    .clk(clk), .rst_n(rst_n), .seg_in(seg_in), .bp_phase(bp_phase),
    .sample_stb(sample_stb), .digit_out(digit_out),
    .match_out(match_out), .no_match(no_match)
  );

  logic [6:0] pat [10] = '{7'h7E, 7'h30, 7'h6D, 7'h79, 7'h33,
                           7'h5B, 7'h5F, 7'h70, 7'h7F, 7'h7B};

  integer m_cnt = 0, m_steps = 0, m_dig = 0;
  bit     m_busy = 0, m_match = 0, m_nm = 0, m_ph = 0;
  logic [6:0] m_seg = 0;
  integer vectors = 0, fails = 0, cycles = 0;
  bit     started = 0;
  string  req = "R1";

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_cnt = 0; m_steps = 0; m_dig = 0;
      m_busy = 0; m_match = 0; m_nm = 0; m_ph = 0; m_seg = 0;
    end else if (sample_stb) begin
      m_seg = seg_in; m_ph = bp_phase; m_busy = 1; m_steps = 0;
      m_match = 0; m_nm = 0;
    end else if (m_busy) begin
      if ((pat[m_cnt] ^ {7{m_ph}}) == m_seg) begin
        m_busy = 0; m_dig = m_cnt; m_match = 1;
      end else begin
        m_cnt = (m_cnt + 1) % 10;
        m_steps = m_steps + 1;
        if (m_steps == 10) begin
          m_busy = 0; m_nm = 1;
        end
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles = cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      summary();
    end
    if (started) begin
      vectors = vectors + 3;
      if (digit_out !== 4'(m_dig)) begin
        fails = fails + 1;
        $display("FAIL %s digit_out: actual %0d expected %0d", req, digit_out, m_dig);
      end
      if (match_out !== m_match) begin
        fails = fails + 1;
        $display("FAIL %s match_out: actual %0b expected %0b", req, match_out, m_match);
      end
      if (no_match !== m_nm) begin
        fails = fails + 1;
        $display("FAIL %s no_match: actual %0b expected %0b", req, no_match, m_nm);
      end
      // R9
      if (match_out === 1'b1 && no_match === 1'b1) begin
        fails = fails + 1;
        $display("FAIL R9 flags: actual both 1 expected at most one");
      end
    end
  end

  task automatic strobe(input logic [6:0] s, input bit ph, input int wait_cycles);
    @(negedge clk);
    seg_in = s; bp_phase = ph; sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    repeat (wait_cycles) @(negedge clk);
  endtask

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2: every digit, true polarity, in a scrambled order so the counter wraps (R4)
    req = "R2";
    foreach (pat[i]) strobe(pat[(i * 7 + 3) % 10], 1'b0, 12);
    // R4: forced wraps from high to low digits
    req = "R4";
    strobe(pat[8], 1'b0, 12);
    strobe(pat[1], 1'b0, 12);
    strobe(pat[9], 1'b0, 12);
    strobe(pat[0], 1'b0, 12);
    // R3: inverted polarity
    req = "R3";
    for (int d = 9; d >= 0; d--) strobe(~pat[d], 1'b1, 12);
    // R5: idle hold
    req = "R5";
    repeat (8) @(negedge clk);
    // R7: inputs change without strobe
    req = "R7";
    for (int k = 0; k < 6; k++) begin
      seg_in = pat[k]; bp_phase = k[0];
      @(negedge clk);
    end
    // R6: unmatched patterns, digit held
    req = "R6";
    strobe(7'h00, 1'b0, 14);
    strobe(pat[5], 1'b1, 14);
    strobe(7'h7F, 1'b1, 14);
    // R8: restart during a search
    req = "R8";
    strobe(pat[2], 1'b0, 0);
    strobe(pat[6], 1'b0, 2);
    strobe(pat[4], 1'b0, 12);
    strobe(7'h01, 1'b0, 4);
    strobe(pat[7], 1'b0, 12);
    summary();
  end
endmodule